// File: doc/BRIEF.md
# Burst Write Command Queue Port

This block takes synchronous burst writes from a host and turns every accepted data word into one queued command. A burst opens when the host pulls its active-low select low and offers words with an active-low data strobe while the read/write flag shows a write. The first accepted word of a burst takes its address from the host address bus. Each later word goes to the next higher address. Every command holds the address, the data word, the two byte-lane enables and the memory/register flag.

The queue can hold 32, 16 or 8 commands, chosen by a two-bit setting. The setting is taken only while the queue is empty. If an accepted word brings the queue up to that capacity, the block ends the burst by driving its active-low stop output. The same happens when a word is offered while the queue is already full. Stop then stays low, and no word is accepted, until the host releases select. A drain side removes at most one command every `DRAIN_CYCLES` clocks while it is enabled. It presents the removed command for one cycle on the command outputs. Both host-side outputs, data-ready and stop, are registered: each reflects the clock edge at which the word was taken or refused.

Top module: `burst_cmd_port`

## Requirements
- R1: The capacity setting `cap_sel_i` selects the capacity: 0 gives 32 commands, 1 gives 16, and 2 or 3 give 8. After reset the capacity is 32.
- R2: A word is accepted at a clock edge when `hst_sel_ni`=0, `hst_strb_ni`=0, `hst_rd_nwr_i`=0, stop is not active, no last word has been accepted in this selection, and the queue holds fewer commands than the capacity. Each accepted word adds exactly one command.
- R3: A command stores the data, the lanes and `hst_mem_nreg_i`. Its address is `hst_addr_i` for the first accepted word since select went low, and the previous word's address plus one (modulo 2^16) for every later word of the selection. Commands leave in arrival order.
- R4: `hst_stop_no` goes low in the cycle after an edge where either (a) an accepted word leaves the queue level equal to the capacity, counting a drain at that same edge, or (b) a write word was offered while the queue was at capacity.
- R5: Once low, `hst_stop_no` stays low while `hst_sel_ni` stays low, and no word is accepted. It returns high in the cycle after an edge with `hst_sel_ni`=1.
- R6: `hst_rdy_no` is low for exactly the one cycle after each edge that accepted a word. It stays high after any refused or ignored word.
- R7: While `drain_en_i`=1 and the queue is not empty, `cmd_pop_o` pulses for one cycle with the head command on the `cmd_*` outputs. After a pulse, at least `DRAIN_CYCLES`-1 cycles pass with no pulse.
- R8: After a word with `hst_last_ni`=0 is accepted, further strobes in the same selection are ignored. No command is added and stop is not raised.
- R9: Strobes with `hst_rd_nwr_i`=1 add no command and raise neither data-ready nor stop.
- R10: A change of `cap_sel_i` while the queue holds commands has no effect until the queue is empty.
- R11: After reset, stop and data-ready are high, the queue is empty, and `cmd_pop_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_sel_i | input | 2 | Capacity setting (0:32, 1:16, 2/3:8) |
| hst_sel_ni | input | 1 | Host select, active low |
| hst_strb_ni | input | 1 | Host data strobe, active low |
| hst_rd_nwr_i | input | 1 | 1 = read, 0 = write |
| hst_mem_nreg_i | input | 1 | 1 = memory target, 0 = register target |
| hst_addr_i | input | 16 | Burst start address |
| hst_data_i | input | 16 | Write data word |
| hst_lanes_i | input | 2 | Byte-lane enables |
| hst_last_ni | input | 1 | Final word of the burst, active low |
| hst_rdy_no | output | 1 | Word-taken pulse, active low |
| hst_stop_no | output | 1 | Burst stop, active low |
| drain_en_i | input | 1 | Permits the drain side to remove commands |
| cmd_pop_o | output | 1 | A command is removed this cycle |
| cmd_addr_o | output | 16 | Removed command address |
| cmd_data_o | output | 16 | Removed command data |
| cmd_lanes_o | output | 2 | Removed command lanes |
| cmd_mem_o | output | 1 | Removed command memory/register flag |

## Verification
Directed bursts at each capacity, with the drain idle, show whether the stop lands on exactly the word that reaches 32, 16 or 8. A burst of four words into an 8-entry queue already half full shows whether stop is raised on the fourth word. Other directed bursts keep select low past a stop, end on a last word, use reads, or change the capacity while commands are queued. These tell sticky stop apart from early release, and a live capacity change apart from one deferred until the queue is empty. Seeded random bursts with strobe gaps, random drain enables and capacity changes make pushes and drains land on the same edge. Those runs separate a correct same-edge level count from an off-by-one in the full test, and they check the address and order of every drained command.

// File: rtl/bcq_pkg.sv
package bcq_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANE_W = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [LANE_W-1:0] lanes;
    logic              is_mem;
  } cmd_t;

  // capacity setting decode: 0 -> 32, 1 -> 16, otherwise 8
  function automatic int unsigned cap_words(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32;
      2'd1:    return 16;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/bcq_ring.sv
module bcq_ring
  import bcq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  cmd_t             push_cmd_i,
  input  logic             pop_i,
  output cmd_t             head_o,
  output logic [LVL_W-1:0] level_o
);
  cmd_t             mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0] level_q, level_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (push_i) wr_ptr_d = wr_ptr_q + PTR_W'(1);
    if (pop_i)  rd_ptr_d = rd_ptr_q + PTR_W'(1);
    case ({push_i, pop_i})
      2'b10:   level_d = level_q + LVL_W'(1);
      2'b01:   level_d = level_q - LVL_W'(1);
      default: level_d = level_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= push_cmd_i;
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign level_o = level_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (level_q != '0)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> (level_q < LVL_W'(DEPTH))); // R2
endmodule

// File: rtl/bcq_pacer.sv
module bcq_pacer #(
  parameter int unsigned DRAIN_CYCLES = 3,
  localparam int unsigned TW = (DRAIN_CYCLES > 1) ? $clog2(DRAIN_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic nonempty_i,
  output logic pop_o
);
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;

  assign pop_o = en_i && nonempty_i && (tmr_q == '0);

  always_comb begin
    tmr_en = pop_o || (tmr_q != '0);
    tmr_d  = tmr_q;
    if (pop_o)               tmr_d = TW'(DRAIN_CYCLES - 1);
    else if (tmr_q != '0)    tmr_d = tmr_q - TW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  if (DRAIN_CYCLES > 1) begin : g_spacing
    AST_DRAIN_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_o |=> !pop_o); // R7
  end
endmodule

// File: rtl/bcq_host_ctl.sv
module bcq_host_ctl
  import bcq_pkg::*;
#(
  parameter int unsigned LVL_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              strb_ni,
  input  logic              rd_nwr_i,
  input  logic              last_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        cap_sel_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic              pop_i,
  output logic              push_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [LVL_W-1:0]  cap_o,
  output logic              rdy_no,
  output logic              stop_no
);
  logic              stop_q, stop_d;
  logic              done_q, done_d;
  logic              first_q, first_d;
  logic              rdy_q;
  logic [ADDR_W-1:0] nxt_addr_q, nxt_addr_d;
  logic [LVL_W-1:0]  cap_q, cap_d;
  logic              cap_en;
  logic              offered, open_w, full_w, refuse;
  logic [LVL_W-1:0]  lvl_after;

  always_comb begin
    offered     = !sel_ni && !strb_ni && !rd_nwr_i;
    open_w      = !stop_q && !done_q;
    full_w      = (level_i >= cap_q);
    push_o      = offered && open_w && !full_w;
    refuse      = offered && open_w && full_w;
    lvl_after   = level_i + LVL_W'(push_o) - LVL_W'(pop_i);
    word_addr_o = first_q ? addr_i : nxt_addr_q;

    stop_d     = sel_ni ? 1'b0 : (stop_q || refuse || (push_o && (lvl_after == cap_q)));
    done_d     = sel_ni ? 1'b0 : (done_q || (push_o && !last_ni));
    first_d    = sel_ni ? 1'b1 : (first_q && !push_o);
    nxt_addr_d = word_addr_o + ADDR_W'(1);
    cap_en     = (level_i == '0);
    cap_d      = LVL_W'(cap_words(cap_sel_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q  <= 1'b0;
      done_q  <= 1'b0;
      first_q <= 1'b1;
      rdy_q   <= 1'b0;
    end else begin
      stop_q  <= stop_d;
      done_q  <= done_d;
      first_q <= first_d;
      rdy_q   <= push_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     nxt_addr_q <= '0;
    else if (push_o) nxt_addr_q <= nxt_addr_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cap_q <= LVL_W'(32);
    else if (cap_en) cap_q <= cap_d;
  end

  assign cap_o   = cap_q;
  assign rdy_no  = !rdy_q;
  assign stop_no = !stop_q;

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_no && !sel_ni) |=> !stop_no); // R5
  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> stop_no); // R5
  AST_CAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i != '0) |=> $stable(cap_q)); // R10
endmodule

// File: rtl/burst_cmd_port.sv
module burst_cmd_port
  import bcq_pkg::*;
#(
  parameter int unsigned DEPTH        = 32,
  parameter int unsigned DRAIN_CYCLES = 3,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cap_sel_i,
  input  logic              hst_sel_ni,
  input  logic              hst_strb_ni,
  input  logic              hst_rd_nwr_i,
  input  logic              hst_mem_nreg_i,
  input  logic [ADDR_W-1:0] hst_addr_i,
  input  logic [DATA_W-1:0] hst_data_i,
  input  logic [LANE_W-1:0] hst_lanes_i,
  input  logic              hst_last_ni,
  output logic              hst_rdy_no,
  output logic              hst_stop_no,
  input  logic              drain_en_i,
  output logic              cmd_pop_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic [LANE_W-1:0] cmd_lanes_o,
  output logic              cmd_mem_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic              push, pop;
  logic [ADDR_W-1:0] word_addr;
  logic [LVL_W-1:0]  level, cap;
  cmd_t              new_cmd, head;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  bcq_host_ctl #(.LVL_W(LVL_W)) i_ctl (
    .clk_i(clk_i), .rst_ni(rst_n),
    .sel_ni(hst_sel_ni), .strb_ni(hst_strb_ni), .rd_nwr_i(hst_rd_nwr_i),
    .last_ni(hst_last_ni), .addr_i(hst_addr_i), .cap_sel_i(cap_sel_i),
    .level_i(level), .pop_i(pop),
    .push_o(push), .word_addr_o(word_addr), .cap_o(cap),
    .rdy_no(hst_rdy_no), .stop_no(hst_stop_no)
  );

  assign new_cmd = '{addr: word_addr, data: hst_data_i, lanes: hst_lanes_i,
                     is_mem: hst_mem_nreg_i};

  bcq_ring #(.DEPTH(DEPTH)) i_ring (
    .clk_i(clk_i), .rst_ni(rst_n),
    .push_i(push), .push_cmd_i(new_cmd), .pop_i(pop),
    .head_o(head), .level_o(level)
  );

  bcq_pacer #(.DRAIN_CYCLES(DRAIN_CYCLES)) i_pacer (
    .clk_i(clk_i), .rst_ni(rst_n),
    .en_i(drain_en_i), .nonempty_i(level != '0), .pop_o(pop)
  );

  assign cmd_pop_o   = pop;
  assign cmd_addr_o  = head.addr;
  assign cmd_data_o  = head.data;
  assign cmd_lanes_o = head.lanes;
  assign cmd_mem_o   = head.is_mem;

  AST_LEVEL_WITHIN_CAP: assert property (@(posedge clk_i) disable iff (!rst_n)
    level <= cap); // R2
  AST_RDY_ON_GROWTH: assert property (@(posedge clk_i) disable iff (!rst_n)
    (level > $past(level)) |-> !hst_rdy_no); // R6
endmodule

// File: tb/test_burst_cmd_port.sv
module test_burst_cmd_port;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DC = 3;

  logic        clk, rst_n;
  logic [1:0]  cap_sel;
  logic        sel_n, strb_n, rd_nwr, mem_nreg, last_n, den;
  logic [15:0] addr, data;
  logic [1:0]  lanes;
  logic        rdy_n, stop_n, pop, c_mem;
  logic [15:0] c_addr, c_data;
  logic [1:0]  c_lanes;

  burst_cmd_port #(.DEPTH(32), .DRAIN_CYCLES(DC)) i_burst_cmd_port (
    .clk_i(clk), .rst_ni(rst_n), .cap_sel_i(cap_sel),
    .hst_sel_ni(sel_n), .hst_strb_ni(strb_n), .hst_rd_nwr_i(rd_nwr),
    .hst_mem_nreg_i(mem_nreg), .hst_addr_i(addr), .hst_data_i(data),
    .hst_lanes_i(lanes), .hst_last_ni(last_n),
    .hst_rdy_no(rdy_n), .hst_stop_no(stop_n), .drain_en_i(den),
    .cmd_pop_o(pop), .cmd_addr_o(c_addr), .cmd_data_o(c_data),
    .cmd_lanes_o(c_lanes), .cmd_mem_o(c_mem)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit fin = 0;

  // reference model state
  int          m_lvl, m_cap, m_tmr, m_head, m_tail;
  bit          m_stop, m_done, m_first;
  logic [15:0] m_nxt;
  logic [15:0] qa [64];
  logic [15:0] qd [64];
  logic [1:0]  ql [64];
  logic        qm [64];
  logic        exp_rdy_n, exp_stop_n;
  int          acc_cnt, stop_cnt;

  function automatic int capw(input logic [1:0] s);
    return (s == 2'd0) ? 32 : (s == 2'd1) ? 16 : 8;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: called at a negative edge, returns at the next one
  task automatic step(input logic s_n, input logic st_n, input logic rd,
                      input logic ln, input logic de);
    bit ep, offered, open_w, push, refuse;
    int after;
    logic [15:0] waddr;
    chk("R6", "rdy_n", 32'(rdy_n), 32'(exp_rdy_n));
    chk("R4", "stop_n", 32'(stop_n), 32'(exp_stop_n));
    if (!rdy_n) acc_cnt++;
    if (!stop_n) stop_cnt++;
    sel_n = s_n; strb_n = st_n; rd_nwr = rd; last_n = ln; den = de;
    addr = 16'($urandom); data = 16'($urandom);
    lanes = 2'($urandom); mem_nreg = 1'($urandom);
    #1;
    ep = de && (m_lvl > 0) && (m_tmr == 0);
    chk("R7", "pop", 32'(pop), 32'(ep));
    if (ep) begin
      chk("R3", "cmd_addr", 32'(c_addr), 32'(qa[m_head]));
      chk("R3", "cmd_data", 32'(c_data), 32'(qd[m_head]));
      chk("R3", "cmd_lanes", 32'(c_lanes), 32'(ql[m_head]));
      chk("R3", "cmd_mem", 32'(c_mem), 32'(qm[m_head]));
    end
    offered = !s_n && !st_n && !rd;
    open_w  = !m_stop && !m_done;
    push    = offered && open_w && (m_lvl < m_cap);
    refuse  = offered && open_w && (m_lvl >= m_cap);
    waddr   = m_first ? addr : m_nxt;
    after   = m_lvl + int'(push) - int'(ep);
    if (ep) begin m_head = (m_head + 1) & 63; m_tmr = DC - 1; end
    else if (m_tmr > 0) m_tmr--;
    if (push) begin
      qa[m_tail] = waddr; qd[m_tail] = data; ql[m_tail] = lanes; qm[m_tail] = mem_nreg;
      m_tail = (m_tail + 1) & 63;
      m_nxt = waddr + 16'd1;
    end
    m_stop  = s_n ? 0 : (m_stop || refuse || (push && after == m_cap));
    m_done  = s_n ? 0 : (m_done || (push && !ln));
    m_first = s_n ? 1 : (m_first && !push);
    if (m_lvl == 0) m_cap = capw(cap_sel);
    m_lvl = after;
    exp_rdy_n  = !push;
    exp_stop_n = !m_stop;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic de);
    for (int i = 0; i < n; i++) step(1, 1, 0, 1, de);
  endtask

  // words in one selection; last_at = word index with last (0: none)
  // dmode 0: drain off, 1: on, 2: random; gaps adds idle strobes
  task automatic words(input int n, input int last_at, input int dmode,
                       input logic rd, input bit gaps);
    for (int i = 1; i <= n; i++) begin
      logic de;
      de = (dmode == 2) ? 1'($urandom) : 1'(dmode);
      if (gaps && ($urandom % 5 == 0)) step(0, 1, rd, 1, de);
      step(0, 0, rd, (i == last_at) ? 1'b0 : 1'b1, de);
    end
  endtask

  task automatic drain_all();
    for (int g = 0; g < 400 && m_lvl > 0; g++) idle(1, 1);
    idle(1, 0);
  endtask

  task automatic phase_start();
    acc_cnt = 0; stop_cnt = 0;
  endtask

  initial begin
    void'($urandom(32'd20250611));
    m_lvl = 0; m_cap = 32; m_tmr = 0; m_head = 0; m_tail = 0;
    m_stop = 0; m_done = 0; m_first = 1; m_nxt = '0;
    exp_rdy_n = 1; exp_stop_n = 1;
    rst_n = 0; cap_sel = 2'd0; sel_n = 1; strb_n = 1; rd_nwr = 0;
    mem_nreg = 0; last_n = 1; den = 0; addr = '0; data = '0; lanes = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R11 reset state
    den = 1; #1;
    chk("R11", "stop_n after reset", 32'(stop_n), 32'd1);
    chk("R11", "rdy_n after reset", 32'(rdy_n), 32'd1);
    chk("R11", "pop after reset", 32'(pop), 32'd0);
    den = 0;
    @(negedge clk);

    // R1: capacity 16
    cap_sel = 2'd1; idle(1, 0);
    phase_start(); words(20, 0, 0, 0, 0); idle(1, 0);
    chk("R1", "words taken at cap 16", 32'(acc_cnt), 32'd16);
    drain_all();

    // R1: setting 3 gives 8
    cap_sel = 2'd3; idle(1, 0);
    phase_start(); words(12, 0, 0, 0, 0); idle(1, 0);
    chk("R1", "words taken at setting 3", 32'(acc_cnt), 32'd8);
    drain_all();

    // R4: 8-entry queue half full, fourth word of the next burst fills it
    cap_sel = 2'd2; idle(1, 0);
    words(4, 4, 0, 0, 0); idle(1, 0);
    phase_start(); words(6, 0, 0, 0, 0); idle(1, 0);
    chk("R4", "words taken before stop", 32'(acc_cnt), 32'd4);
    chk("R4", "stop cycles seen", 32'(stop_cnt > 0), 32'd1);
    // R4: word offered while already full is refused with stop
    phase_start(); words(1, 0, 0, 0, 0); idle(1, 0);
    chk("R4", "refused word on full queue", 32'(acc_cnt), 32'd0);
    chk("R4", "stop on refused word", 32'(stop_cnt), 32'd1);
    drain_all();

    // R10: capacity change with commands queued is deferred
    cap_sel = 2'd0; idle(1, 0);
    words(2, 2, 0, 0, 0); idle(1, 0);
    cap_sel = 2'd2;
    phase_start(); words(40, 0, 0, 0, 0); idle(1, 0);
    chk("R10", "words taken with deferred setting", 32'(acc_cnt), 32'd30);
    drain_all();
    cap_sel = 2'd0; idle(1, 0);

    // R8: last word ends acceptance without stop
    phase_start(); words(5, 2, 0, 0, 0); idle(1, 0);
    chk("R8", "words taken after last", 32'(acc_cnt), 32'd2);
    chk("R8", "stop cycles after last", 32'(stop_cnt), 32'd0);
    drain_all();

    // R9: read strobes ignored
    phase_start(); words(6, 0, 1, 1, 0); idle(1, 0);
    chk("R9", "read strobes taken", 32'(acc_cnt), 32'd0);
    chk("R9", "stop on reads", 32'(stop_cnt), 32'd0);

    // R5: stop holds while select stays low, even as room appears
    cap_sel = 2'd2; idle(1, 0);
    phase_start(); words(8, 0, 0, 0, 0); words(10, 0, 1, 0, 0); idle(1, 0);
    chk("R5", "words taken across held stop", 32'(acc_cnt), 32'd8);
    chk("R5", "stop released after deselect", 32'(stop_n), 32'd1);
    drain_all();

    // R2 R3 R7: seeded random bursts
    for (int it = 0; it < 300; it++) begin
      int n, la;
      if ($urandom % 4 == 0) cap_sel = 2'($urandom);
      n  = 1 + int'($urandom % 12);
      la = ($urandom % 3 == 0) ? 1 + int'($urandom % n) : 0;
      words(n, la, 2, ($urandom % 10 == 0) ? 1'b1 : 1'b0, 1);
      idle(1 + int'($urandom % 3), 1'($urandom));
      if ($urandom % 4 == 0) drain_all();
    end
    drain_all();

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule